// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This engine sits on the byte stream between a NAND page buffer and the flash. It takes one page of 2,112 bytes, one byte per accepted cycle. The page holds 2,048 data bytes, which are four back-to-back 512-byte sectors, followed by 64 spare bytes. For every sector it builds a 24-bit single-error-correcting, double-error-detecting parity code.

On a write pass, the host streams the page through the engine. When the stream reaches a code slot, the engine raises an insert strobe and supplies the code byte, and the host puts that byte into the page in place of whatever it carried.

On a read pass, the engine rebuilds the codes from the incoming data and compares them with the stored code bytes. It then reports a verdict for each sector: clean, a single correctable bit (with its byte and bit position), damage confined to the stored code, or uncorrectable. The engine never alters the data. Repair is left to the consumer of the report.

Top module: `nand_ecc_engine`

## Requirements
- R1: A byte is accepted when `in_valid` is high. If `sop` is high with that byte, it is page byte 0, and the byte counter and parity state restart. This holds even in the middle of a page. A `sop` seen while `in_valid` is low is ignored.
- R2: In write mode (`wr_mode`=1), `ecc_ins` is high in the same cycle as each accepted byte at page indices 2048 to 2059, and at no other time. `ecc_byte` is zero whenever `ecc_ins` is low. Read mode never raises `ecc_ins`.
- R3: Sector n (0 to 3) owns page indices 2048+3n to 2050+3n.
  - Let L[2a+v] be the XOR of the bit-parities of all bytes in the sector whose in-sector byte offset has bit a equal to v (a from 0 to 8).
  - Let C[2c+v] be the XOR of all data bits whose bit index has bit c equal to v (c from 0 to 2).
  - The first code byte is L[7:0], the second is L[15:8], and the third is {C[5:0], L[17:16]}.
- R4: On a read pass, a sector whose data and stored code agree reports code 0 (clean).
- R5: A single flipped data bit reports code 1 (correctable). `st_byte` gives its offset within the sector (0 to 511) and `st_bit` gives its bit index (0 to 7).
- R6: A single flipped bit anywhere in a sector's three stored code bytes, with good data, reports code 2 (code field error).
- R7: Any two flipped bits in a sector report code 3 (uncorrectable), whether both are in the data, both in the code, or one in each.
- R8: `st_valid` pulses for exactly one cycle, in the cycle after the sector's third stored code byte is accepted. It carries the sector number in `st_sector`. `st_byte` and `st_bit` are zero unless the code is 1.
- R9: Spare bytes at indices 2060 to 2111, and the data input during idle cycles, have no effect on any report or strobe.
- R10: While `rst` is high and in the cycle after it, `st_valid` and `ecc_ins` are low and `ecc_byte` is zero.
- R11: Idle cycles (`in_valid` low) inserted anywhere in a page do not change any code byte or report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 1 | 1 = write pass (insert codes), 0 = read pass (check codes) |
| sop | input | 1 | Marks the accepted byte as page byte 0 |
| in_valid | input | 1 | The byte on `in_data` is accepted this cycle |
| in_data | input | 8 | Page byte |
| ecc_ins | output | 1 | Code byte must replace the current byte |
| ecc_byte | output | 8 | Code byte to insert |
| st_valid | output | 1 | One-cycle sector report strobe |
| st_code | output | 2 | 0 clean, 1 correctable, 2 code field error, 3 uncorrectable |
| st_sector | output | 2 | Sector the report belongs to |
| st_byte | output | 9 | Byte offset within the sector of a correctable error |
| st_bit | output | 3 | Bit index of a correctable error |

## Verification
The properties assume that `wr_mode` stays constant throughout a pass. They also assume that each page starts with `sop` on its first accepted byte, which guarantees that the third code bytes of consecutive sectors arrive at least three accepted bytes apart. The stimulus holds the mode fixed for each whole page. It begins every page with `sop` on byte 0, and it inserts idle cycles only between accepted bytes. Those idle cycles carry junk data and stray `sop` pulses, so the stimulus checks that unaccepted cycles are ignored rather than assuming quiet inputs.

// File: rtl/nand_ecc_pkg.sv
`timescale 1ns/1ps
package nand_ecc_pkg;

    // page geometry
    localparam int SECT_BYTES  = 512;
    localparam int NUM_SECT    = 4;
    localparam int SPARE_BYTES = 64;
    localparam int CODE_BYTES  = 3;

    localparam int DATA_BYTES  = SECT_BYTES * NUM_SECT;
    localparam int PAGE_BYTES  = DATA_BYTES + SPARE_BYTES;
    localparam int ECC_BYTES   = CODE_BYTES * NUM_SECT;
    localparam int OFF_W       = $clog2(SECT_BYTES);
    localparam int BIT_W       = 3;
    localparam int SEC_W       = $clog2(NUM_SECT);
    localparam int IDX_W       = $clog2(PAGE_BYTES);
    localparam int EOFF_W      = $clog2(ECC_BYTES);
    localparam int CB_W        = $clog2(CODE_BYTES);
    localparam int LINE_W      = 2 * OFF_W;
    localparam int COL_W       = 2 * BIT_W;
    localparam int CODE_W      = 8 * CODE_BYTES;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIXABLE  = 2'd1,
        ST_CODE_ERR = 2'd2,
        ST_FATAL    = 2'd3
    } ecc_stat_e;

    // column pairs on top, line pairs below: byte order of the spare slots
    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
    } ecc_code_t;

    typedef struct packed {
        ecc_stat_e         stat;
        logic [SEC_W-1:0]  sector;
        logic [OFF_W-1:0]  byte_loc;
        logic [BIT_W-1:0]  bit_loc;
    } ecc_report_t;

    // fold one byte's parity into the line-pair vector
    function automatic logic [LINE_W-1:0] line_fold(
        input logic [LINE_W-1:0] acc,
        input logic [OFF_W-1:0]  offs,
        input logic              pb
    );
        logic [LINE_W-1:0] r;
        r = acc;
        for (int a = 0; a < OFF_W; a++) begin
            if (offs[a]) r[2*a+1] = r[2*a+1] ^ pb;
            else         r[2*a]   = r[2*a]   ^ pb;
        end
        return r;
    endfunction

    // reduce the running XOR of all bytes into column pairs
    function automatic logic [COL_W-1:0] col_reduce(input logic [7:0] x);
        logic [COL_W-1:0] r;
        r = '0;
        for (int b = 0; b < 8; b++) begin
            for (int c = 0; c < BIT_W; c++) begin
                if ((b >> c) & 1) r[2*c+1] = r[2*c+1] ^ x[b];
                else              r[2*c]   = r[2*c]   ^ x[b];
            end
        end
        return r;
    endfunction

    // classify the difference between stored and rebuilt codes
    function automatic ecc_report_t judge(
        input ecc_code_t        syn,
        input logic [SEC_W-1:0] sec
    );
        ecc_report_t r;
        logic        split_all;
        int          ones;
        r        = '0;
        r.sector = sec;
        split_all = 1'b1;
        for (int a = 0; a < OFF_W; a++)
            split_all = split_all & (syn.line[2*a] ^ syn.line[2*a+1]);
        for (int c = 0; c < BIT_W; c++)
            split_all = split_all & (syn.col[2*c] ^ syn.col[2*c+1]);
        ones = $countones(syn);
        if (syn == '0) begin
            r.stat = ST_CLEAN;
        end else if (split_all) begin
            r.stat = ST_FIXABLE;
            for (int a = 0; a < OFF_W; a++) r.byte_loc[a] = syn.line[2*a+1];
            for (int c = 0; c < BIT_W; c++) r.bit_loc[c] = syn.col[2*c+1];
        end else if (ones == 1) begin
            r.stat = ST_CODE_ERR;
        end else begin
            r.stat = ST_FATAL;
        end
        return r;
    endfunction

endpackage

// File: rtl/nand_ecc_index.sv
`timescale 1ns/1ps
module nand_ecc_index
    import nand_ecc_pkg::*;
#(
    parameter int PAGE = PAGE_BYTES,
    parameter int W    = $clog2(PAGE)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic         restart,
    output logic [W-1:0] idx
);

    logic [W-1:0] cnt_q;

    // a restart makes the current byte index zero
    assign idx = restart ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (take) begin
            if (idx == W'(PAGE - 1)) cnt_q <= '0;
            else                     cnt_q <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/nand_ecc_accum.sv
`timescale 1ns/1ps
module nand_ecc_accum
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic             done,
    output logic [SEC_W-1:0] done_sec,
    output ecc_code_t        code
);

    logic [LINE_W-1:0] line_q, line_base, line_n;
    logic [7:0]        xor_q, xor_base, xor_n;
    logic [OFF_W-1:0]  offs;
    logic              in_data_zone;
    logic              first;

    assign offs         = idx[OFF_W-1:0];
    assign in_data_zone = idx < IDX_W'(DATA_BYTES);
    assign first        = (offs == '0);

    // sector start drops whatever the previous sector left behind
    assign line_base = first ? '0 : line_q;
    assign xor_base  = first ? '0 : xor_q;
    assign line_n    = line_fold(line_base, offs, ^din);
    assign xor_n     = xor_base ^ din;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            xor_q  <= '0;
        end else if (take && in_data_zone) begin
            line_q <= line_n;
            xor_q  <= xor_n;
        end
    end

    assign done      = take && in_data_zone && (offs == OFF_W'(SECT_BYTES - 1));
    assign done_sec  = idx[OFF_W +: SEC_W];
    assign code.line = line_n;
    assign code.col  = col_reduce(xor_n);

endmodule

// File: rtl/nand_ecc_bank.sv
`timescale 1ns/1ps
module nand_ecc_bank
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEC_W-1:0] wr_sec,
    input  ecc_code_t        wr_code,
    input  logic [SEC_W-1:0] rd_sec,
    output ecc_code_t        rd_code
);

    ecc_code_t slot_w [NUM_SECT];

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_slot
        ecc_code_t held;
        always_ff @(posedge clk) begin
            if (rst)                                   held <= '0;
            else if (wr_en && (wr_sec == SEC_W'(g)))   held <= wr_code;
        end
        assign slot_w[g] = held;
    end

    assign rd_code = slot_w[rd_sec];

endmodule

// File: rtl/nand_ecc_judge.sv
`timescale 1ns/1ps
module nand_ecc_judge
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  ecc_code_t        syn,
    input  logic [SEC_W-1:0] sec,
    output logic             vld,
    output ecc_report_t      rep
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            rep <= '0;
        end else begin
            vld <= fire;
            if (fire) rep <= judge(syn, sec);
        end
    end

endmodule

// File: rtl/nand_ecc_engine.sv
`timescale 1ns/1ps
module nand_ecc_engine
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_mode,
    input  logic             sop,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             ecc_ins,
    output logic [7:0]       ecc_byte,
    output logic             st_valid,
    output logic [1:0]       st_code,
    output logic [SEC_W-1:0] st_sector,
    output logic [OFF_W-1:0] st_byte,
    output logic [BIT_W-1:0] st_bit
);

    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  rel;
    logic [EOFF_W-1:0] eoff;
    logic [SEC_W-1:0]  esec;
    logic [CB_W-1:0]   ebyte;
    logic              in_zone;
    logic              last_slot;
    logic              acc_done;
    logic [SEC_W-1:0]  acc_sec;
    ecc_code_t         acc_code;
    ecc_code_t         code_sel;
    logic [CODE_W-1:0] code_vec;
    logic [CODE_BYTES-2:0][7:0] stash_q;
    logic [CODE_W-1:0] stored;
    logic              judge_fire;
    ecc_report_t       rep;

    nand_ecc_index #(.PAGE(PAGE_BYTES), .W(IDX_W)) u_index (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid),
        .restart (sop && in_valid),
        .idx     (idx)
    );

    nand_ecc_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .take     (in_valid),
        .idx      (idx),
        .din      (in_data),
        .done     (acc_done),
        .done_sec (acc_sec),
        .code     (acc_code)
    );

    // locate the current byte among the code slots
    assign in_zone   = in_valid && (idx >= IDX_W'(DATA_BYTES))
                                && (idx <  IDX_W'(DATA_BYTES + ECC_BYTES));
    assign rel       = idx - IDX_W'(DATA_BYTES);
    assign eoff      = rel[EOFF_W-1:0];
    assign esec      = SEC_W'(eoff / EOFF_W'(CODE_BYTES));
    assign ebyte     = CB_W'(eoff % EOFF_W'(CODE_BYTES));
    assign last_slot = (ebyte == CB_W'(CODE_BYTES - 1));

    nand_ecc_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc_done),
        .wr_sec  (acc_sec),
        .wr_code (acc_code),
        .rd_sec  (esec),
        .rd_code (code_sel)
    );

    assign code_vec = code_sel;

    // write pass: hand out the code byte for the slot being passed
    always_comb begin
        ecc_ins  = in_zone && wr_mode;
        ecc_byte = '0;
        if (ecc_ins) ecc_byte = code_vec[{ebyte, 3'b000} +: 8];
    end

    // read pass: collect the leading stored bytes of a code
    always_ff @(posedge clk) begin
        if (rst) begin
            stash_q <= '0;
        end else if (in_zone && !wr_mode && !last_slot) begin
            stash_q <= {in_data, stash_q[CODE_BYTES-2:1]};
        end
    end

    assign stored     = {in_data, stash_q};
    assign judge_fire = in_zone && !wr_mode && last_slot;

    nand_ecc_judge u_judge (
        .clk  (clk),
        .rst  (rst),
        .fire (judge_fire),
        .syn  (code_sel ^ ecc_code_t'(stored)),
        .sec  (esec),
        .vld  (st_valid),
        .rep  (rep)
    );

    assign st_code   = rep.stat;
    assign st_sector = rep.sector;
    assign st_byte   = rep.byte_loc;
    assign st_bit    = rep.bit_loc;

endmodule

// File: rtl/nand_ecc_chk.sv
`timescale 1ns/1ps
module nand_ecc_chk
    import nand_ecc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_mode,
    input logic             sop,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             ecc_ins,
    input logic [7:0]       ecc_byte,
    input logic             st_valid,
    input logic [1:0]       st_code,
    input logic [SEC_W-1:0] st_sector,
    input logic [OFF_W-1:0] st_byte,
    input logic [BIT_W-1:0] st_bit
);

    // R2: insert strobe only with an accepted byte in write mode
    p_ins_write_only_r2: assert property (@(posedge clk) disable iff (rst)
        ecc_ins |-> (wr_mode && in_valid));

    // R8: a report always follows an accepted read-pass byte
    p_stat_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> $past(in_valid && !wr_mode));

    // R8: the report strobe lasts one cycle
    p_stat_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        st_valid |=> !st_valid);

    // R8: locations are zero unless the error is correctable
    p_loc_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (st_valid && (st_code != 2'd1)) |-> ((st_byte == '0) && (st_bit == '0)));

    // R2: no code byte is driven while the strobe is low
    p_byte_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !ecc_ins |-> (ecc_byte == 8'h00));

endmodule

bind nand_ecc_engine nand_ecc_chk u_chk (.*);

// File: tb/nand_ecc_engine_tb.sv
`timescale 1ns/1ps
module nand_ecc_engine_tb;
    import nand_ecc_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_mode = 1'b0;
    logic             sop = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             ecc_ins;
    logic [7:0]       ecc_byte;
    logic             st_valid;
    logic [1:0]       st_code;
    logic [SEC_W-1:0] st_sector;
    logic [OFF_W-1:0] st_byte;
    logic [BIT_W-1:0] st_bit;

    always #2.5 clk = ~clk;

    nand_ecc_engine u_dut (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .sop(sop), .in_valid(in_valid),
        .in_data(in_data), .ecc_ins(ecc_ins), .ecc_byte(ecc_byte),
        .st_valid(st_valid), .st_code(st_code), .st_sector(st_sector),
        .st_byte(st_byte), .st_bit(st_bit)
    );

    typedef struct {
        bit    is_stat;
        int    due;
        int    val;
        string req;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] page [PAGE_BYTES];
    int         exp_val [NUM_SECT];
    string      exp_req [NUM_SECT];
    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         rng = 32'h2468ace1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int nxt();
        rng = rng * 1103515245 + 12345;
        return (rng >>> 16) & 32'h7fff;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // R3 model: per-bit definition of the line and column pairs
    function automatic logic [23:0] ref_code(input int s);
        logic [17:0] ln;
        logic [5:0]  cl;
        ln = '0;
        cl = '0;
        for (int i = 0; i < SECT_BYTES; i++)
            for (int b = 0; b < 8; b++)
                if (page[s*SECT_BYTES + i][b]) begin
                    for (int a = 0; a < 9; a++) ln[2*a + ((i >> a) & 1)] ^= 1'b1;
                    for (int c = 0; c < 3; c++) cl[2*c + ((b >> c) & 1)] ^= 1'b1;
                end
        return {cl, ln};
    endfunction

    function automatic int pack_rep(input int code, input int sec, input int by, input int bi);
        return (code << 16) | (sec << 12) | (by << 3) | bi;
    endfunction

    task automatic fill(input int kind);
        for (int i = 0; i < PAGE_BYTES; i++) begin
            case (kind)
                0:       page[i] = 8'((i * 37) + (i >> 5) * 11 + 3);
                1:       page[i] = 8'(i ^ ((i >> 4) * 5));
                2:       page[i] = 8'hFF;
                default: page[i] = 8'(nxt());
            endcase
        end
    endtask

    task automatic seal();
        for (int s = 0; s < NUM_SECT; s++) begin
            logic [23:0] c;
            c = ref_code(s);
            page[DATA_BYTES + 3*s]     = c[7:0];
            page[DATA_BYTES + 3*s + 1] = c[15:8];
            page[DATA_BYTES + 3*s + 2] = c[23:16];
        end
    endtask

    task automatic expect_all(input int code, input string req);
        for (int s = 0; s < NUM_SECT; s++) begin
            exp_val[s] = pack_rep(code, s, 0, 0);
            exp_req[s] = req;
        end
    endtask

    // driver: streams bytes and pushes what the monitor must see
    task automatic send(input bit wr, input bit stalls, input int nbytes, input string req);
        logic [23:0] cw [NUM_SECT];
        int i;
        for (int s = 0; s < NUM_SECT; s++) cw[s] = ref_code(s);
        i = 0;
        while (i < nbytes) begin
            @(posedge clk); #1;
            if (stalls && (nxt() % 4 == 0)) begin
                // R1/R9/R11: idle cycle with junk data and a stray sop
                in_valid = 1'b0;
                sop      = (nxt() % 2 == 0);
                in_data  = 8'(nxt());
            end else begin
                in_valid = 1'b1;
                sop      = (i == 0);
                wr_mode  = wr;
                in_data  = page[i];
                if (i >= DATA_BYTES && i < DATA_BYTES + ECC_BYTES) begin
                    int   k;
                    exp_t e;
                    k = i - DATA_BYTES;
                    if (wr) begin
                        e.is_stat = 1'b0;
                        e.due     = cyc;
                        e.val     = int'(cw[k/3][8*(k%3) +: 8]);
                        e.req     = req;
                        sb.push_back(e);
                    end else if (k % 3 == 2) begin
                        e.is_stat = 1'b1;
                        e.due     = cyc + 1;
                        e.val     = exp_val[k/3];
                        e.req     = exp_req[k/3];
                        sb.push_back(e);
                    end
                end
                i++;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        sop      = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(sb.size() == 0, "R8", "outputs still owed after pass", sb.size(), 0);
        sb.delete();
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (ecc_ins) begin
                if (sb.size() == 0 || sb[0].is_stat) begin
                    check(1'b0, "R2", "unexpected insert strobe", int'(ecc_byte), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(ecc_byte) == e.val, e.req, "code byte", int'(ecc_byte), e.val);
                    check(cyc == e.due, "R2", "insert cycle", cyc, e.due);
                end
            end
            if (st_valid) begin
                if (sb.size() == 0 || !sb[0].is_stat) begin
                    check(1'b0, "R8", "unexpected report",
                          pack_rep(st_code, st_sector, st_byte, st_bit), -1);
                end else begin
                    exp_t e;
                    int   act;
                    e   = sb.pop_front();
                    act = pack_rep(int'(st_code), int'(st_sector), int'(st_byte), int'(st_bit));
                    check(act == e.val, e.req, "sector report", act, e.val);
                    check(cyc == e.due, "R8", "report cycle", cyc, e.due);
                end
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: quiet outputs under reset
        check(!st_valid && !ecc_ins && ecc_byte == 8'h00, "R10", "reset outputs",
              {st_valid, ecc_ins, ecc_byte}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(!st_valid && !ecc_ins, "R10", "first cycle after reset", {st_valid, ecc_ins}, 0);

        // R2 R3: write pass, steady stream
        fill(0);
        send(1'b1, 1'b0, PAGE_BYTES, "R3");
        // R11: write pass with idle cycles
        fill(1);
        send(1'b1, 1'b1, PAGE_BYTES, "R11");
        // R3: all-ones page gives an all-zero code
        fill(2);
        send(1'b1, 1'b0, PAGE_BYTES, "R3");

        // R4 R9: clean read, random spare
        fill(0);
        seal();
        for (int i = DATA_BYTES + ECC_BYTES; i < PAGE_BYTES; i++) page[i] = 8'(nxt());
        expect_all(0, "R4");
        send(1'b0, 1'b0, PAGE_BYTES, "R4");
        // R9 R11: different spare contents, stalls
        for (int i = DATA_BYTES + ECC_BYTES; i < PAGE_BYTES; i++) page[i] = 8'(nxt());
        expect_all(0, "R9");
        send(1'b0, 1'b1, PAGE_BYTES, "R9");

        // R5 R6 R7: mixed damage
        page[0]                  ^= 8'h01;
        page[SECT_BYTES + 511]   ^= 8'h80;
        page[DATA_BYTES + 7]     ^= 8'h10;
        page[3*SECT_BYTES + 100] ^= 8'h03;
        exp_val[0] = pack_rep(1, 0, 0, 0);   exp_req[0] = "R5";
        exp_val[1] = pack_rep(1, 1, 511, 7); exp_req[1] = "R5";
        exp_val[2] = pack_rep(2, 2, 0, 0);   exp_req[2] = "R6";
        exp_val[3] = pack_rep(3, 3, 0, 0);   exp_req[3] = "R7";
        send(1'b0, 1'b1, PAGE_BYTES, "R5");

        // R5 R7: second damage pattern
        fill(1);
        seal();
        page[341]                ^= 8'h20;
        page[SECT_BYTES + 170]   ^= 8'h04;
        page[DATA_BYTES + 3]     ^= 8'h01;
        page[DATA_BYTES + 6]     ^= 8'h81;
        exp_val[0] = pack_rep(1, 0, 341, 5); exp_req[0] = "R5";
        exp_val[1] = pack_rep(3, 1, 0, 0);   exp_req[1] = "R7";
        exp_val[2] = pack_rep(3, 2, 0, 0);   exp_req[2] = "R7";
        exp_val[3] = pack_rep(0, 3, 0, 0);   exp_req[3] = "R4";
        send(1'b0, 1'b0, PAGE_BYTES, "R7");

        // R1: abandoned page, then a fresh page restarted by sop
        fill(3);
        send(1'b0, 1'b0, 700, "R1");
        fill(1);
        seal();
        page[3*SECT_BYTES + 7] ^= 8'h40;
        expect_all(0, "R1");
        exp_val[3] = pack_rep(1, 3, 7, 6);
        send(1'b0, 1'b1, PAGE_BYTES, "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule